// File: doc/BRIEF.md
# Latched Channel-Select Controller with Break-Before-Make

This block drives the enable lines of a bank of sixteen channel switches. A host presents a channel number and an enable bit together with an active-low write strobe. While the strobe is low the holding register follows those inputs on every clock. When the strobe rises, the last values seen while it was low stay held. A separate active-low clear input empties the holding register, and with it every switch. The held selection is decoded into a switch-enable vector that is either all zeros or has a single active channel.

A build parameter picks the channel arrangement. In single-ended mode each of the sixteen codes drives its own switch. In paired mode the bank is two halves of eight. Only the low three code bits are used, and the matching switch in each half turns on together. Whenever an active selection is dropped or replaced, the controller first turns everything off and holds the vector at zero for a parameterised number of clock cycles before it enables the next channel. Two channels therefore never conduct at once.

Top module: `latched_sel_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, the holding register is cleared and the sequencer returns to idle. `sw_en` is all zeros in the cycle after that edge and stays zero until a write with enable 1 has been accepted.
- R2: At each clock edge where `wr_n` is low and `clear_n` is high, the holding register takes `en_in` and `addr_in`. From an idle state, the new selection appears on `sw_en` after the following edge, so two edges after the input was sampled.
- R3: At each clock edge where `wr_n` and `clear_n` are both high, the holding register keeps its value. Changes on `en_in` and `addr_in` then have no effect on `sw_en`.
- R4: At a clock edge where `clear_n` is low, the held enable and code are cleared whatever `wr_n` is, so clear wins over the strobe. `sw_en` is all zeros from the second edge after clear was sampled.
- R5: When the held enable is 0, `sw_en` is all zeros from the next clock edge on, whatever the held code.
- R6: With `PAIR_MODE`=0 and the held enable at 1, a held code n (0 to 15) drives only bit n of `sw_en`. Bit n is the switch for channel n+1.
- R7: With `PAIR_MODE`=1 and the held enable at 1, the code bits [2:0] = n drive bits n and n+8 of `sw_en`. Bit 3 of the code is ignored: changing only that bit leaves `sw_en` unchanged, with no off gap.
- R8: `sw_en` is always all zeros or one-hot. In paired mode the lower eight bits are all zeros or one-hot, and the upper eight bits equal them.
- R9: When an active selection is dropped or changes to a different channel, `sw_en` goes to all zeros at the next edge. It stays all zeros for exactly `GAP_CYC` cycles before any channel turns on again. `sw_en` never moves directly from one non-zero value to another.
- R10: When the target changes again during the off gap, the channel enabled at the end of the gap is the target held at that moment. If the held enable is 0 at that moment, `sw_en` stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear_n | input | 1 | Clears the held selection, active low, takes priority over the strobe |
| wr_n | input | 1 | Write strobe, active low; register transparent while low |
| en_in | input | 1 | Enable value to be held |
| addr_in | input | 4 | Channel code to be held |
| sw_en | output | 16 | Switch enables; in paired mode bits 7:0 are half A and bits 15:8 are half B |

## Verification
The bench builds two instances side by side from the same stimulus. One is single-ended with `GAP_CYC`=2. The other is paired with `GAP_CYC`=3, so two gap lengths are covered and the ignored code bit shows up as a difference between the two (the paired one holds its channel while the single-ended one runs a gap). A long random phase mixes strobe pulses, held-low transparent runs, clears and occasional resets. That phase reaches retargeting inside a gap and a clear that collides with a write, both of which the directed phases only touch once.

// File: rtl/lsel_pkg.sv
package lsel_pkg;

    localparam int unsigned SEL_ADDR_W = 4;
    localparam int unsigned SEL_NUM    = 1 << SEL_ADDR_W;
    localparam int unsigned SEL_HALF   = SEL_NUM / 2;

    typedef logic [SEL_ADDR_W-1:0] sel_code_t;

    typedef struct packed {
        logic      en;
        sel_code_t code;
    } sel_req_t;

    typedef enum logic [1:0] {
        SEQ_OFF = 2'd0,
        SEQ_ON  = 2'd1,
        SEQ_GAP = 2'd2
    } seq_state_e;

    // In paired mode the top code bit does not take part in the selection.
    function automatic sel_code_t fold_code(input sel_code_t c, input bit pair);
        sel_code_t r;
        r = c;
        if (pair) r[SEL_ADDR_W-1] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/sel_hold_latch.sv
module sel_hold_latch
    import lsel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear_n,
    input  logic     wr_n,
    input  sel_req_t req_i,
    output sel_req_t held_o
);

    sel_req_t held_q;

    always_ff @(posedge clk) begin
        if (rst || !clear_n) begin
            held_q <= '0;
        end else if (!wr_n) begin
            held_q <= req_i;
        end
    end

    assign held_o = held_q;

    // R3: strobe high and no clear keeps the held selection
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (clear_n && wr_n) |=> $stable(held_q));

    // R4: a clear empties the register even while the strobe is low
    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> (held_q == '0));

endmodule

// File: rtl/bbm_sequencer.sv
module bbm_sequencer
    import lsel_pkg::*;
#(
    parameter int unsigned GAP_CYC = 2
)(
    input  logic      clk,
    input  logic      rst,
    input  sel_req_t  tgt_i,
    output logic      on_o,
    output sel_code_t code_o
);

    localparam int unsigned CNT_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(GAP_CYC - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    sel_code_t        code_q;
    logic             diverge;

    assign diverge = !tgt_i.en || (tgt_i.code != code_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_OFF;
            cnt_q   <= '0;
            code_q  <= '0;
        end else begin
            case (state_q)
                SEQ_OFF: begin
                    if (tgt_i.en) begin
                        state_q <= SEQ_ON;
                        code_q  <= tgt_i.code;
                    end
                end
                SEQ_ON: begin
                    if (diverge) begin
                        state_q <= SEQ_GAP;
                        cnt_q   <= CNT_LOAD;
                    end
                end
                SEQ_GAP: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (tgt_i.en) begin
                        state_q <= SEQ_ON;
                        code_q  <= tgt_i.code;
                    end else begin
                        state_q <= SEQ_OFF;
                    end
                end
                default: state_q <= SEQ_OFF;
            endcase
        end
    end

    assign on_o   = (state_q == SEQ_ON);
    assign code_o = code_q;

    // R5: a dropped enable never leaves the sequencer driving
    assert_drop_R5: assert property (@(posedge clk) disable iff (rst)
        !tgt_i.en |=> !on_o);

endmodule

// File: rtl/switch_decode.sv
module switch_decode
    import lsel_pkg::*;
#(
    parameter bit PAIR_MODE = 1'b0
)(
    input  logic               on_i,
    input  sel_code_t          code_i,
    output logic [SEL_NUM-1:0] sw_o
);

    generate
        if (PAIR_MODE) begin : g_pair
            for (genvar i = 0; i < SEL_HALF; i++) begin : g_bit
                logic hit;
                assign hit              = on_i && (code_i == SEL_ADDR_W'(i));
                assign sw_o[i]          = hit;
                assign sw_o[i+SEL_HALF] = hit;
            end
        end else begin : g_single
            for (genvar i = 0; i < SEL_NUM; i++) begin : g_bit
                assign sw_o[i] = on_i && (code_i == SEL_ADDR_W'(i));
            end
        end
    endgenerate

endmodule

// File: rtl/latched_sel_ctl.sv
module latched_sel_ctl
    import lsel_pkg::*;
#(
    parameter int unsigned GAP_CYC   = 2,
    parameter bit          PAIR_MODE = 1'b0
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear_n,
    input  logic                  wr_n,
    input  logic                  en_in,
    input  logic [SEL_ADDR_W-1:0] addr_in,
    output logic [SEL_NUM-1:0]    sw_en
);

    localparam int unsigned RUN_W = $clog2(GAP_CYC + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(GAP_CYC);

    sel_req_t  req_in;
    sel_req_t  held;
    sel_req_t  tgt;
    logic      drv_on;
    sel_code_t drv_code;

    assign req_in.en   = en_in;
    assign req_in.code = addr_in;

    sel_hold_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .clear_n (clear_n),
        .wr_n    (wr_n),
        .req_i   (req_in),
        .held_o  (held)
    );

    assign tgt.en   = held.en;
    assign tgt.code = fold_code(held.code, PAIR_MODE);

    bbm_sequencer #(.GAP_CYC(GAP_CYC)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .tgt_i  (tgt),
        .on_o   (drv_on),
        .code_o (drv_code)
    );

    switch_decode #(.PAIR_MODE(PAIR_MODE)) u_dec (
        .on_i   (drv_on),
        .code_i (drv_code),
        .sw_o   (sw_en)
    );

    // Off-run counter used only by the gap property below.
    logic             any_on;
    logic [RUN_W-1:0] off_run_q;

    assign any_on = |sw_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_run_q <= RUN_MAX;
        end else if (any_on) begin
            off_run_q <= '0;
        end else if (off_run_q != RUN_MAX) begin
            off_run_q <= off_run_q + 1'b1;
        end
    end

    // R9: every turn-on follows at least GAP_CYC all-zero cycles
    assert_gap_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(any_on) |-> (off_run_q == RUN_MAX));

    // R9: no direct move between two non-zero vectors
    assert_nodirect_R9: assert property (@(posedge clk) disable iff (rst)
        (any_on && $past(any_on)) |-> (sw_en == $past(sw_en)));

    // R4: clear reaches the switches by the second edge
    assert_clear_out_R4: assert property (@(posedge clk) disable iff (rst)
        !clear_n |-> ##2 (sw_en == '0));

    // R5: held enable low forces the switches off
    assert_en_off_R5: assert property (@(posedge clk) disable iff (rst)
        !held.en |=> (sw_en == '0));

    generate
        if (PAIR_MODE) begin : g_chk_pair
            // R8: one-hot per half, halves identical
            assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
                $onehot0(sw_en[SEL_HALF-1:0]) &&
                (sw_en[SEL_NUM-1:SEL_HALF] == sw_en[SEL_HALF-1:0]));
        end else begin : g_chk_single
            // R8: zero or one-hot
            assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
                $onehot0(sw_en));
        end
    endgenerate

endmodule

// File: tb/latched_sel_ctl_tb.sv
`timescale 1ns/1ps
module latched_sel_ctl_tb;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst, clear_n, wr_n, en_in;
    logic [3:0]  addr_in;
    logic [15:0] sw_s, sw_d;

    latched_sel_ctl #(.GAP_CYC(2), .PAIR_MODE(1'b0)) u_dut (
        .clk(clk), .rst(rst), .clear_n(clear_n), .wr_n(wr_n),
        .en_in(en_in), .addr_in(addr_in), .sw_en(sw_s));

    latched_sel_ctl #(.GAP_CYC(3), .PAIR_MODE(1'b1)) u_dut_pair (
        .clk(clk), .rst(rst), .clear_n(clear_n), .wr_n(wr_n),
        .en_in(en_in), .addr_in(addr_in), .sw_en(sw_d));

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    checking = 0;
    bit    done = 0;
    string req_tag = "R1";

    // Behavioural reference: held selection, then per-instance off/on/gap timing.
    int m_en = 0, m_addr = 0;
    int m_st[2], m_code[2], m_cnt[2];
    int m_gap[2] = '{2, 3};

    always @(posedge clk) begin
        for (int m = 0; m < 2; m++) begin
            int tc;
            tc = (m == 1) ? (m_addr % 8) : m_addr;
            if (rst) begin
                m_st[m] = 0; m_cnt[m] = 0; m_code[m] = 0;
            end else if (m_st[m] == 0) begin
                if (m_en != 0) begin m_st[m] = 1; m_code[m] = tc; end
            end else if (m_st[m] == 1) begin
                if (m_en == 0 || tc != m_code[m]) begin
                    m_st[m] = 2; m_cnt[m] = m_gap[m] - 1;
                end
            end else begin
                if (m_cnt[m] > 0) m_cnt[m]--;
                else if (m_en != 0) begin m_st[m] = 1; m_code[m] = tc; end
                else m_st[m] = 0;
            end
        end
        if (rst || !clear_n) begin
            m_en = 0; m_addr = 0;
        end else if (!wr_n) begin
            m_en = int'(en_in); m_addr = int'(addr_in);
        end
    end

    function automatic logic [15:0] expv(int m);
        logic [15:0] v;
        v = '0;
        if (m_st[m] == 1) begin
            v[m_code[m]] = 1'b1;
            if (m == 1) v[m_code[m] + 8] = 1'b1;
        end
        return v;
    endfunction

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at cycle %0d", req, got, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the reference, plus shape check (R8).
    always @(negedge clk) begin
        if (checking && !done) begin
            check(req_tag, sw_s, expv(0));
            check(req_tag, sw_d, expv(1));
            n_vec++;
            if (!($countones(sw_s) <= 1 && $countones(sw_d[7:0]) <= 1 &&
                  sw_d[15:8] == sw_d[7:0])) begin
                n_bad++;
                $display("FAIL R8: got %h/%h expected one-hot shapes", sw_s, sw_d);
            end
        end
    end

    task automatic report();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL R2: watchdog expired, got no end expected end");
            report();
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(bit e, logic [3:0] a);
        @(negedge clk);
        wr_n = 1'b0; en_in = e; addr_in = a;
        @(negedge clk);
        wr_n = 1'b1;
    endtask

    initial begin
        rst = 1'b1; clear_n = 1'b1; wr_n = 1'b1; en_in = 1'b0; addr_in = 4'd0;
        idle(2);
        checking = 1;
        idle(1);
        rst = 1'b0;
        // R1 / R3: idle after reset with inputs moving but no strobe
        req_tag = "R1"; en_in = 1'b1; addr_in = 4'd5;
        idle(4);
        check("R1", sw_s, 16'h0000);
        check("R3", sw_d, 16'h0000);

        // R2 / R6: a strobe pulse from idle
        req_tag = "R6";
        write(1'b1, 4'd3);
        @(negedge clk);
        check("R6", sw_s, 16'h0008);
        check("R7", sw_d, 16'h0808);

        // R7: only the top code bit changes; paired instance must hold
        req_tag = "R7";
        write(1'b1, 4'd11);
        @(negedge clk);
        check("R9", sw_s, 16'h0000);
        check("R7", sw_d, 16'h0808);
        idle(4);
        check("R6", sw_s, 16'h0800);

        // R6 / R9: sweep every code
        req_tag = "R9";
        for (int a = 0; a < 16; a++) begin
            write(1'b1, 4'(a));
            idle(5);
        end

        // R2 / R10: transparent run with changes inside the gap
        req_tag = "R10";
        @(negedge clk); wr_n = 1'b0;
        for (int a = 0; a < 6; a++) begin
            en_in = 1'b1; addr_in = 4'((a * 5) % 16);
            @(negedge clk);
        end
        idle(4);
        wr_n = 1'b1;

        // R3: inputs move with strobe high
        req_tag = "R3";
        for (int a = 0; a < 6; a++) begin
            en_in = a[0]; addr_in = 4'(a + 7);
            @(negedge clk);
        end
        idle(4);

        // R5: enable 0 written
        req_tag = "R5";
        write(1'b0, 4'd7);
        idle(6);
        check("R5", sw_s, 16'h0000);
        check("R5", sw_d, 16'h0000);

        // R4: clear collides with a write
        req_tag = "R4";
        write(1'b1, 4'd2);
        idle(6);
        wr_n = 1'b0; en_in = 1'b1; addr_in = 4'd9; clear_n = 1'b0;
        idle(2);
        clear_n = 1'b1; wr_n = 1'b1;
        idle(5);
        check("R4", sw_s, 16'h0000);
        check("R4", sw_d, 16'h0000);

        // Random mix of all controls
        req_tag = "R2";
        for (int i = 0; i < 4000; i++) begin
            wr_n    = ($urandom_range(0, 3) != 0);
            en_in   = ($urandom_range(0, 4) != 0);
            addr_in = 4'($urandom_range(0, 15));
            clear_n = ($urandom_range(0, 30) != 0);
            rst     = ($urandom_range(0, 700) == 0);
            req_tag = rst ? "R1" : (!clear_n ? "R4" : (wr_n ? "R3" : "R9"));
            @(negedge clk);
        end
        rst = 1'b0; clear_n = 1'b1; wr_n = 1'b1;
        idle(6);
        report();
    end

endmodule